// File: doc/BRIEF.md
# Johnson Decade Counter with Decoded Outputs

A divide-by-ten counter whose state lives in a twisted ring of flops: each advance shifts the ring one place, and the inverse of the top bit enters at the bottom. The ten resulting patterns are decoded, each by a two-input gate, into ten one-hot lines that go high in turn. A terminal-count line is high for the first half of the cycle and low for the second half. Its rising edge therefore marks the wrap from the last count back to count zero.

All logic runs on one fast system clock. The external count clock, the active-high count inhibit and the master clear are synchronised through two flops each. Edge detectors then produce the two events that advance the count. The first is a rising edge of the count clock while the inhibit is low. The second is a falling edge of the inhibit while the count clock is high. The master clear and an active-low power-on reset both return the ring to count zero. The raw ring state is also brought out.

Top module: `johnson_decade`

## Requirements
- R1: The ring is STAGES (default 5) bits wide. From count 0 (all zeros), count k for k below STAGES has its k low bits set. Count STAGES is all ones. Count STAGES+k has its k low bits clear and the rest set. Each advance moves to the next count, and count 9 moves to count 0. Any ring pattern outside these ten is replaced by zero on the next advance.
- R2: Exactly one bit of decOut is high at any time, and bit k is high exactly when the ring holds count k.
- R3: A rising edge of cntClk while cntInhibit is low advances the count by one. Ten such edges return the count to 0.
- R4: A falling edge of cntInhibit while cntClk is high advances the count by one.
- R5: A falling edge of cntClk, a rising edge of cntInhibit, any cntClk activity while cntInhibit is high, and a falling edge of cntInhibit while cntClk is low all leave the count unchanged.
- R6: termCount is high for counts 0 to 4 and low for counts 5 to 9.
- R7: While masterClr is high, the count is forced to 0 (decOut bit 0 high) regardless of cntClk and cntInhibit.
- R8: rstN low clears the ring to count 0 immediately, without waiting for a clock edge.
- R9: A rising cntClk edge and a falling cntInhibit edge in the same sampling cycle give a single advance. A change at an input is reflected at the outputs after at most three sysClk rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock; all flops use its rising edge |
| rstN | input | 1 | Asynchronous active-low reset to count 0 |
| cntClk | input | 1 | Count clock, sampled and edge-detected |
| cntInhibit | input | 1 | High blocks counting; its falling edge counts while cntClk is high |
| masterClr | input | 1 | Synchronous clear to count 0 after synchronisation |
| decOut | output | 10 | One-hot decoded count, bit k for count k |
| termCount | output | 1 | High for counts 0 to 4 |
| ringState | output | 5 | Raw Johnson ring bits |

## Verification
The count clock is run through more than two full decades with the inhibit low, and every state is checked against an arithmetic model. This shows the shift order, the one-hot decode and the terminal-count split at each count. Pulses while the inhibit is high and lone falling clock edges separate the counting edges from the ignored ones. Inhibit edges with the clock held high and with it held low check that the alternate path depends on the clock level. A simultaneous clock rise and inhibit fall checks that the two paths together advance the count only once. The clear is tested during clock activity in mid-count, and the asynchronous reset is tested in mid-count.

// File: rtl/johnson_pkg.sv
package johnson_pkg;
  // Strobes the control sends to the ring datapath each system cycle.
  typedef struct packed {
    logic advance;
    logic clear;
  } ringCmd_t;
endpackage

// File: rtl/johnson_ctrl.sv
module johnson_ctrl
  import johnson_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic     sysClk,
  input  logic     rstN,
  input  logic     cntClk,
  input  logic     cntInhibit,
  input  logic     masterClr,
  output ringCmd_t cmd
);
  // One extra stage beyond the synchroniser holds the previous value.
  localparam int PIPE_W = SYNC_DEPTH + 1;

  logic [PIPE_W-1:0]     clkPipe;
  logic [PIPE_W-1:0]     inhPipe;
  logic [SYNC_DEPTH-1:0] clrPipe;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      clkPipe <= '0;
      inhPipe <= '0;
      clrPipe <= '0;
    end else begin
      clkPipe <= {clkPipe[PIPE_W-2:0], cntClk};
      inhPipe <= {inhPipe[PIPE_W-2:0], cntInhibit};
      clrPipe <= {clrPipe[SYNC_DEPTH-2:0], masterClr};
    end
  end

  logic clkNow, clkPrev, inhNow, inhPrev;
  logic clkRise, inhFall;

  always_comb begin
    clkNow  = clkPipe[SYNC_DEPTH-1];
    clkPrev = clkPipe[SYNC_DEPTH];
    inhNow  = inhPipe[SYNC_DEPTH-1];
    inhPrev = inhPipe[SYNC_DEPTH];
    // Count clock rises while inhibit is low.
    clkRise = clkNow && !clkPrev && !inhNow;
    // Inhibit falls while count clock is high.
    inhFall = inhPrev && !inhNow && clkNow;
    // Both paths together give a single advance.
    cmd.advance = clkRise || inhFall;
    cmd.clear   = clrPipe[SYNC_DEPTH-1];
  end
endmodule

// File: rtl/johnson_ring.sv
module johnson_ring
  import johnson_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic                  sysClk,
  input  logic                  rstN,
  input  ringCmd_t              cmd,
  output logic [STAGES-1:0]     ringQ,
  output logic [2*STAGES-1:0]   decoded,
  output logic                  halfHigh
);
  localparam int MODULUS = 2 * STAGES;

  logic [STAGES-1:0] ringNext;
  logic              legal;

  // A legal Johnson pattern has at most one adjacent-bit transition.
  always_comb begin
    legal = ($countones(ringQ[STAGES-1:1] ^ ringQ[STAGES-2:0]) <= 1);
    ringNext = ringQ;
    if (cmd.clear) begin
      ringNext = '0;
    end else if (cmd.advance) begin
      ringNext = legal ? {ringQ[STAGES-2:0], ~ringQ[STAGES-1]} : '0;
    end
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) ringQ <= '0;
    else       ringQ <= ringNext;
  end

  // Two-input decode per count.
  assign decoded[0]      = ~ringQ[0] & ~ringQ[STAGES-1];
  assign decoded[STAGES] =  ringQ[0] &  ringQ[STAGES-1];

  for (genvar k = 1; k < STAGES; k++) begin : g_decode
    assign decoded[k]          =  ringQ[k-1] & ~ringQ[k];
    assign decoded[STAGES + k] = ~ringQ[k-1] &  ringQ[k];
  end

  // High for the first half of the cycle.
  assign halfHigh = ~ringQ[STAGES-1];

  if (MODULUS < 4) begin : g_bad_size
    initial $error("johnson_ring needs STAGES of at least 2");
  end
endmodule

// File: rtl/johnson_decade.sv
module johnson_decade
  import johnson_pkg::*;
#(
  parameter int STAGES     = 5,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                sysClk,
  input  logic                rstN,
  input  logic                cntClk,
  input  logic                cntInhibit,
  input  logic                masterClr,
  output logic [2*STAGES-1:0] decOut,
  output logic                termCount,
  output logic [STAGES-1:0]   ringState
);
  ringCmd_t cmd;

  johnson_ctrl #(.SYNC_DEPTH(SYNC_DEPTH)) ctrl_i (
    .sysClk     (sysClk),
    .rstN       (rstN),
    .cntClk     (cntClk),
    .cntInhibit (cntInhibit),
    .masterClr  (masterClr),
    .cmd        (cmd)
  );

  johnson_ring #(.STAGES(STAGES)) ring_i (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .cmd      (cmd),
    .ringQ    (ringState),
    .decoded  (decOut),
    .halfHigh (termCount)
  );
endmodule

// File: rtl/johnson_decade_chk.sv
module johnson_decade_chk #(
  parameter int STAGES = 5
) (
  input logic                sysClk,
  input logic                rstN,
  input logic                masterClr,
  input logic [2*STAGES-1:0] decOut,
  input logic                termCount,
  input logic [STAGES-1:0]   ringState
);
  logic [1:0] clrRun;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN)                    clrRun <= '0;
    else if (!masterClr)          clrRun <= '0;
    else if (clrRun != 2'd3)      clrRun <= clrRun + 2'd1;
  end

  // R2: one-hot decode
  assert_onehot_R2: assert property (@(posedge sysClk) disable iff (!rstN)
    $countones(decOut) == 1);

  // R6: terminal count matches the lower half of the decoded lines
  assert_tc_half_R6: assert property (@(posedge sysClk) disable iff (!rstN)
    termCount == (|decOut[STAGES-1:0]));

  // R1: the ring either holds, takes one Johnson step, or goes to zero
  assert_ring_step_R1: assert property (@(posedge sysClk) disable iff (!rstN)
    !$stable(ringState) |->
      (ringState == '0) ||
      (ringState == {$past(ringState[STAGES-2:0]), ~$past(ringState[STAGES-1])}));

  // R1: only legal patterns are reachable
  assert_ring_legal_R1: assert property (@(posedge sysClk) disable iff (!rstN)
    $countones(ringState[STAGES-1:1] ^ ringState[STAGES-2:0]) <= 1);

  // R7: a held clear reaches the ring within three edges
  assert_clear_held_R7: assert property (@(posedge sysClk) disable iff (!rstN)
    (clrRun == 2'd3 && masterClr) |-> (ringState == '0));
endmodule

bind johnson_decade johnson_decade_chk #(.STAGES(STAGES)) chk_i (
  .sysClk    (sysClk),
  .rstN      (rstN),
  .masterClr (masterClr),
  .decOut    (decOut),
  .termCount (termCount),
  .ringState (ringState)
);

// File: tb/johnson_decade_tb_top.sv
module johnson_decade_tb_top;
  localparam int STAGES = 5;
  localparam int MOD    = 2 * STAGES;

  logic sysClk = 1'b0;
  logic rstN   = 1'b0;
  logic cntClk = 1'b0;
  logic cntInhibit = 1'b0;
  logic masterClr  = 1'b0;
  logic [MOD-1:0]    decOut;
  logic              termCount;
  logic [STAGES-1:0] ringState;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 1'b0;

  always #10 sysClk = ~sysClk;

  johnson_decade dut_i (
    .sysClk     (sysClk),
    .rstN       (rstN),
    .cntClk     (cntClk),
    .cntInhibit (cntInhibit),
    .masterClr  (masterClr),
    .decOut     (decOut),
    .termCount  (termCount),
    .ringState  (ringState)
  );

  function automatic logic [STAGES-1:0] ringOf(int c);
    logic [STAGES-1:0] ones = '1;
    if (c < STAGES) return STAGES'((1 << c) - 1);
    return ones << (c - STAGES);
  endfunction

  task automatic checkAll(string req);
    logic [MOD-1:0] expDec = MOD'(1) << model;
    logic expTc = (model < STAGES);
    checks++;
    if (ringState !== ringOf(model)) begin
      fails++;
      $display("FAIL %s ring actual=%b expected=%b", req, ringState, ringOf(model));
    end
    checks++;
    if (decOut !== expDec) begin
      fails++;
      $display("FAIL %s decode actual=%b expected=%b", req, decOut, expDec);
    end
    checks++;
    if (termCount !== expTc) begin
      fails++;
      $display("FAIL %s tc actual=%b expected=%b", req, termCount, expTc);
    end
  endtask

  // Wait past the synchroniser and ring update, then sample mid-cycle.
  task automatic settle();
    repeat (4) @(posedge sysClk);
    @(negedge sysClk);
  endtask

  task automatic bump();
    model = (model + 1) % MOD;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge sysClk);
    checkAll("R8 reset");
    rstN = 1'b1;
    settle();
    checkAll("R8 after release");

    // R3/R5/R6/R2: 25 rising edges, with lone falling edges between.
    for (int i = 0; i < 25; i++) begin
      cntClk = 1'b1; settle(); bump();
      checkAll("R3 rise advance");
      cntClk = 1'b0; settle();
      checkAll("R5 fall ignored");
      if (i == 9) begin
        checks++;
        if (model != 0 || ringState !== '0) begin
          fails++;
          $display("FAIL R3 wrap actual=%b expected=%b", ringState, 5'b0);
        end
      end
    end

    // R5: pulses while inhibited
    cntInhibit = 1'b1; settle();
    checkAll("R5 inhibit rise ignored");
    for (int i = 0; i < 4; i++) begin
      cntClk = 1'b1; settle();
      cntClk = 1'b0; settle();
      checkAll("R5 pulse while inhibited");
    end

    // R4: inhibit falls while clock high
    cntClk = 1'b1; settle();
    checkAll("R5 clock rise while inhibited");
    cntInhibit = 1'b0; settle(); bump();
    checkAll("R4 inhibit fall with clock high");
    cntInhibit = 1'b1; settle();
    checkAll("R5 inhibit rise with clock high");
    cntInhibit = 1'b0; settle(); bump();
    checkAll("R4 second inhibit fall");

    // R5: inhibit fall while clock low
    cntClk = 1'b0; settle();
    cntInhibit = 1'b1; settle();
    cntInhibit = 1'b0; settle();
    checkAll("R5 inhibit fall with clock low");

    // R9: coincident clock rise and inhibit fall
    cntInhibit = 1'b1; settle();
    cntClk = 1'b1; cntInhibit = 1'b0; settle(); bump();
    checkAll("R9 coincident edges single advance");
    cntClk = 1'b0; settle();

    // Advance to mid-count, then clear with clock activity.
    for (int i = 0; i < 3; i++) begin
      cntClk = 1'b1; settle(); bump();
      cntClk = 1'b0; settle();
    end
    checkAll("R3 before clear");
    masterClr = 1'b1; settle(); model = 0;
    checkAll("R7 clear applied");
    for (int i = 0; i < 3; i++) begin
      cntClk = 1'b1; settle();
      cntClk = 1'b0; settle();
      checkAll("R7 clear overrides clock");
    end
    masterClr = 1'b0; settle();
    cntClk = 1'b1; settle(); bump();
    checkAll("R7 counts after clear");
    cntClk = 1'b0; settle();

    // R8: asynchronous reset mid-count
    for (int i = 0; i < 4; i++) begin
      cntClk = 1'b1; settle(); bump();
      cntClk = 1'b0; settle();
    end
    #3 rstN = 1'b0; #2; model = 0;
    checkAll("R8 async reset mid-count");
    @(negedge sysClk); rstN = 1'b1;
    settle();
    checkAll("R8 after second release");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule